// File: doc/BRIEF.md
# Fire Code Burst-Error Decoder

This block receives a 224-bit block one bit at a time: 184 data bits, then 40 check bits. The check bits were computed with the degree-40 Fire generator g(x) = x^40 + x^26 + x^23 + x^17 + x^3 + 1, which is the product (x^23 + 1)(x^17 + x^3 + 1). They were sent complemented. The decoder corrects any single error burst no longer than 12 bits.

As bits arrive, the block keeps the data portion in an internal buffer. It also folds every bit, with the check bits re-inverted, into a 40-bit syndrome register. That register is premultiplied so that a trapped burst lines up with its frame position. A zero syndrome means the block is clean.

Otherwise the register keeps shifting with its input cut off, one step per cycle. It stops when its upper 28 bits are all zero. At that point the step count is the window position, and the low 12 bits are the error pattern. The pattern is then XORed into the buffered data. If no trap occurs within 224 steps, the block reports the data as uncorrectable.

Top module: `fire_burst_decoder`

## Requirements
- R1: After reset, `in_ready_o` is 1. `done_o`, `clean_o`, `fixed_o`, `fail_o` and `chk_only_o` are all 0.
- R2: A bit is taken on each edge where `in_valid_i` and `in_ready_o` are both 1. Frame position p counts from 0, the first bit. After the 224th bit `in_ready_o` stays 0 until `done_o`, and bits offered while it is 0 have no effect on any later result.
- R3: The check bits are the complement of the remainder of d(x)·x^40 mod g(x), most significant bit sent first. The first data bit has the highest degree. An error-free block gives `clean_o`=1, `pos_o`=0 and `pat_o`=0. `done_o` rises 1 cycle after the edge that took the last bit.
- R4: `done_o` is high for exactly one cycle. The status outputs, `pos_o`, `pat_o` and `data_o` keep their values on the cycle after it.
- R5: While `done_o` is high, exactly one of `clean_o`, `fixed_o` and `fail_o` is 1.
- R6: For a correctable burst, let L be the last wrong position. Then `fixed_o`=1 and `pos_o` = max(0, L-11). Bit k of `pat_o` is 1 exactly when position `pos_o`+11-k was wrong. `done_o` rises `pos_o`+1 cycles after the last input edge.
- R7: After a correction, `data_o` equals the data that was sent. Position p is held at `data_o[183-p]`.
- R8: If every wrong bit lies at positions 184 to 223, `fixed_o` and `chk_only_o` are both 1 and `data_o` is left unchanged. `chk_only_o` is 0 whenever a data bit was wrong.
- R9: If no trap occurs in 224 run steps, `fail_o`=1, `pos_o`=0 and `pat_o`=0. `data_o` keeps the received data. `done_o` rises 225 cycles after the last input edge.
- R10: `data_o` changes only on an edge that takes a data bit, or on the edge that raises `done_o` with a real data correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input bit offered |
| in_bit_i | input | 1 | Serial received bit |
| in_ready_o | output | 1 | Block accepts input bits |
| done_o | output | 1 | One-cycle completion pulse |
| clean_o | output | 1 | Block had no error |
| fixed_o | output | 1 | Burst trapped and corrected |
| fail_o | output | 1 | Error not correctable |
| chk_only_o | output | 1 | Trapped burst touched only check bits |
| pos_o | output | 8 | Start of trapped 12-bit window |
| pat_o | output | 12 | Trapped error pattern, bit 11 at `pos_o` |
| data_o | output | 184 | Data buffer, position p at bit 183-p |

## Verification
On every cycle, assertions check the following:
- the completion pulse is one cycle wide and its status is one-hot;
- the data buffer moves only on accepted data bits or at a correction;
- a check-only or non-corrected outcome leaves the buffer alone, while a true data correction alters it.

Only the directed scenarios can show whether the decoding itself is right. That covers the trapped window position and pattern for bursts near the frame start, across the data/check boundary and at the last position. It also covers the restored data, the latency that follows from the position, and rejection of input offered while the run phase is under way.

// File: rtl/fire_burst_decoder.sv
module fire_burst_decoder #(
  parameter int DATA_BITS = 184,
  parameter int CHK_BITS  = 40,
  parameter int PAT_BITS  = 12,
  parameter logic [CHK_BITS-1:0] GEN_LOW = 40'h00_0482_0009
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic                 in_bit_i,
  output logic                 in_ready_o,
  output logic                 done_o,
  output logic                 clean_o,
  output logic                 fixed_o,
  output logic                 fail_o,
  output logic                 chk_only_o,
  output logic [7:0]           pos_o,
  output logic [PAT_BITS-1:0]  pat_o,
  output logic [DATA_BITS-1:0] data_o
);

  localparam int NBITS = DATA_BITS + CHK_BITS;
  localparam int CW = $clog2(NBITS + 1);
  localparam logic [CW-1:0] NB_C = CW'(NBITS);
  localparam logic [CW-1:0] CK_C = CW'(CHK_BITS);

  function automatic logic [CHK_BITS-1:0] premult();
    logic [CHK_BITS:0] v;
    v = 1;
    for (int i = 0; i < NBITS - PAT_BITS; i++) begin
      if (v[0]) v = v ^ {1'b1, GEN_LOW};
      v = v >> 1;
    end
    return v[CHK_BITS-1:0];
  endfunction

  localparam logic [CHK_BITS-1:0] PRE = premult();

  typedef enum logic {ST_IN, ST_RUN} st_t;
  st_t st;

  logic [CHK_BITS-1:0] syn;
  logic [CW-1:0]       cnt;

  wire take = in_valid_i && in_ready_o;
  assign in_ready_o = (st == ST_IN);

  wire in_chk = (cnt <= CK_C);
  wire u      = in_bit_i ^ in_chk;
  wire [CHK_BITS-1:0] fb      = syn[CHK_BITS-1] ? GEN_LOW : '0;
  wire [CHK_BITS-1:0] shifted = {syn[CHK_BITS-2:0], 1'b0} ^ fb;
  wire trapped  = (syn[CHK_BITS-1:PAT_BITS] == '0);
  wire syn_zero = (syn == '0);
  wire [CW-1:0] run_pos = NB_C - cnt;
  wire [NBITS-1:0] fmask = {syn[PAT_BITS-1:0], {(NBITS-PAT_BITS){1'b0}}} >> run_pos;
  wire [DATA_BITS-1:0] dmask = fmask[NBITS-1:CHK_BITS];
  wire finish = syn_zero || (cnt == '0) || trapped;
  wire do_fix = !syn_zero && (cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= ST_IN;
      syn        <= '0;
      cnt        <= NB_C;
      data_o     <= '0;
      done_o     <= 1'b0;
      clean_o    <= 1'b0;
      fixed_o    <= 1'b0;
      fail_o     <= 1'b0;
      chk_only_o <= 1'b0;
      pos_o      <= '0;
      pat_o      <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_IN: if (take) begin
          syn <= shifted ^ (u ? PRE : '0);
          if (!in_chk) data_o <= {data_o[DATA_BITS-2:0], in_bit_i};
          if (cnt == CW'(1)) begin
            st  <= ST_RUN;
            cnt <= NB_C;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RUN: if (finish) begin
          done_o     <= 1'b1;
          clean_o    <= syn_zero;
          fail_o     <= !syn_zero && (cnt == '0);
          fixed_o    <= do_fix;
          chk_only_o <= do_fix && (dmask == '0);
          pos_o      <= do_fix ? 8'(run_pos) : '0;
          pat_o      <= do_fix ? syn[PAT_BITS-1:0] : '0;
          if (do_fix) data_o <= data_o ^ dmask;
          st  <= ST_IN;
          syn <= '0;
          cnt <= NB_C;
        end else begin
          syn <= shifted;
          cnt <= cnt - 1'b1;
        end
        default: st <= ST_IN;
      endcase
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  status_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot({clean_o, fixed_o, fail_o}));

  // R10
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> (done_o || $stable(data_o)));

  // R8
  no_touch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (!fixed_o || chk_only_o)) |-> $stable(data_o));

  // R7
  real_fix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fixed_o && !chk_only_o) |-> !$stable(data_o));

  // R2
  ready_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> in_ready_o);

endmodule

// File: tb/fire_burst_decoder_tb_top.sv
module fire_burst_decoder_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, in_bit = 0;
  logic in_ready, done, clean, fixed, fail, chk_only;
  logic [7:0] pos;
  logic [11:0] pat;
  logic [183:0] data;
  int total = 0, bad = 0;
  bit finished = 0;

  localparam logic [39:0] GEN = 40'h00_0482_0009;

  always #4 clk = ~clk;

  fire_burst_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_bit_i(in_bit),
    .in_ready_o(in_ready), .done_o(done), .clean_o(clean), .fixed_o(fixed),
    .fail_o(fail), .chk_only_o(chk_only), .pos_o(pos), .pat_o(pat), .data_o(data));

  task automatic check(input bit ok, input string req, input string what,
                       input string act, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%s expected=%s", req, what, act, exp);
    end
  endtask

  function automatic string s(input longint v);
    return $sformatf("%0h", v);
  endfunction

  // Sends one encoded block with error vector err (bit p = frame position p)
  task automatic check_block(input logic [223:0] err, input bit exp_fail, input bit noise);
    logic [223:0] fr;
    logic [39:0] r;
    logic [183:0] sent, rx;
    int last, epos, elat, lat;
    logic [11:0] epat;
    bit echk, seen;
    logic [7:0] hp;
    logic [11:0] hpat;
    logic [183:0] hdata;
    r = '0;
    for (int p = 0; p < 184; p++) begin
      logic fbk;
      fr[p] = 1'($urandom);
      fbk = fr[p] ^ r[39];
      r = {r[38:0], 1'b0} ^ (fbk ? GEN : 40'h0);
    end
    for (int i = 0; i < 40; i++) fr[184 + i] = ~r[39 - i];
    for (int p = 0; p < 184; p++) begin
      sent[183 - p] = fr[p];
      rx[183 - p] = fr[p] ^ err[p];
    end
    last = -1;
    for (int p = 0; p < 224; p++) if (err[p]) last = p;
    epos = 0; epat = '0; echk = 1;
    if (last >= 0 && !exp_fail) begin
      epos = (last < 11) ? 0 : last - 11;
      for (int k = 0; k < 12; k++) epat[k] = err[epos + 11 - k];
      for (int p = 0; p < 184; p++) if (err[p]) echk = 0;
    end
    elat = (last < 0) ? 1 : (exp_fail ? 225 : epos + 1);

    for (int p = 0; p < 224; p++) begin
      @(negedge clk);
      in_valid = 1;
      in_bit = fr[p] ^ err[p];
    end
    lat = 0; seen = 0;
    for (int c = 0; c < 400 && !seen; c++) begin
      @(negedge clk);
      if (c == 0) check(in_ready == 0, "R2", "ready low after 224 bits", s(in_ready), "0");
      if (done) begin
        seen = 1;
        in_valid = 0;
      end else begin
        lat++;
        in_valid = noise;
        in_bit = 1'($urandom);
      end
    end
    in_valid = 0;
    check(seen, "R4", "done seen", s(seen), "1");
    if (last < 0) begin
      check(clean == 1, "R3", "clean", s(clean), "1");
      check(lat == elat, "R3", "clean latency", s(lat), s(elat));
    end else if (exp_fail) begin
      check(fail == 1, "R9", "fail", s(fail), "1");
      check(lat == elat, "R9", "fail latency", s(lat), s(elat));
      check(data == rx, "R9", "data kept", $sformatf("%h", data), $sformatf("%h", rx));
    end else begin
      check(fixed == 1, "R6", "fixed", s(fixed), "1");
      check(lat == elat, "R6", "fix latency", s(lat), s(elat));
      check(chk_only == echk, "R8", "check-only flag", s(chk_only), s(echk));
    end
    check($countones({clean, fixed, fail}) == 1, "R5", "one status", s({clean, fixed, fail}), "onehot");
    check(pos == 8'(epos), "R6", "position", s(pos), s(epos));
    check(pat == epat, "R6", "pattern", s(pat), s(epat));
    if (!exp_fail)
      check(data == sent, "R7", "data restored", $sformatf("%h", data), $sformatf("%h", sent));
    hp = pos; hpat = pat; hdata = data;
    @(negedge clk);
    check(done == 0, "R4", "done one cycle", s(done), "0");
    check(pos == hp && pat == hpat && data == hdata, "R4", "outputs held",
          s(pos), s(hp));
    check(in_ready == 1, "R2", "ready again", s(in_ready), "1");
  endtask

  task automatic t_reset;
    check(in_ready == 1, "R1", "ready", s(in_ready), "1");
    check(done == 0 && clean == 0 && fixed == 0 && fail == 0 && chk_only == 0,
          "R1", "status idle", s({done, clean, fixed, fail, chk_only}), "0");
  endtask

  task automatic t_clean;
    check_block('0, 0, 0);
  endtask

  task automatic t_single_data;
    logic [223:0] e = '0;
    e[50] = 1;
    check_block(e, 0, 0);
    check(pos == 8'd39 && pat == 12'h001, "R6", "single bit window", s({pos, pat}), "27001");
  endtask

  task automatic t_full_burst;
    logic [223:0] e = '0;
    for (int p = 100; p < 112; p++) e[p] = 1;
    check_block(e, 0, 0);
    check(pos == 8'd100 && pat == 12'hfff, "R6", "12-bit burst", s({pos, pat}), "64fff");
  endtask

  task automatic t_early_burst;
    logic [223:0] e = '0;
    e[3] = 1; e[7] = 1;
    check_block(e, 0, 0);
    check(pos == 8'd0 && pat == 12'h110, "R6", "clamped window", s({pos, pat}), "0110");
  endtask

  task automatic t_straddle;
    logic [223:0] e = '0;
    e[180] = 1; e[182] = 1; e[185] = 1; e[187] = 1;
    check_block(e, 0, 0);
    check(chk_only == 0, "R8", "straddle not check-only", s(chk_only), "0");
  endtask

  task automatic t_check_only;
    logic [223:0] e = '0;
    e[200] = 1; e[203] = 1; e[205] = 1;
    check_block(e, 0, 0);
    check(chk_only == 1, "R8", "check-only burst", s(chk_only), "1");
    e = '0;
    e[223] = 1;
    check_block(e, 0, 0);
    check(pos == 8'd212 && chk_only == 1, "R8", "last position", s(pos), "d4");
  endtask

  task automatic t_uncorrectable;
    logic [223:0] e = '0;
    e[5] = 1; e[100] = 1;
    check_block(e, 1, 1);
  endtask

  task automatic t_after_noise;
    check_block('0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_clean;
    t_single_data;
    t_full_burst;
    t_early_burst;
    t_straddle;
    t_check_only;
    t_uncorrectable;
    t_after_noise;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule